// File: doc/BRIEF.md
# Iterative Multiply/Divide Unit

A multi-cycle arithmetic unit for the eight integer multiply and divide operations of a 32-bit processor: the low and high halves of a product (with signed×signed, signed×unsigned and unsigned×unsigned high-half variants), and signed and unsigned quotient and remainder. A request is a one-cycle `start_i` pulse that carries the opcode and both operands. The unit holds `busy_o` while it works. It then raises `done_o` for one cycle, and `result_o` carries the 32-bit answer in that cycle.

The latency depends on the data. A low-half multiply runs a shift-add loop and stops as soon as the remaining multiplier bits are zero, so small second operands finish quickly. High-half multiplies and non-trivial divisions always run the full 32 steps. A zero divisor is found before the loop starts and finishes almost at once. Signed operands are turned into magnitudes first. The sign of the answer is applied at the end through one shared conditional negator.

Top module: `seq_muldiv`

## Requirements
- R1: The opcode `op_i` is 0 MUL, 1 MULH, 2 MULHSU, 3 MULHU, 4 DIV, 5 DIVU, 6 REM, 7 REMU. A request is accepted at a rising edge where `start_i` is high and `busy_o` is low.
- R2: `busy_o` is high from the cycle after acceptance up to the cycle before `done_o`. `done_o` is high for exactly one cycle, and `busy_o` is low in that cycle.
- R3: `start_i` while `busy_o` is high is ignored. The operation in flight keeps its timing and its result.
- R4: MUL returns the low 32 bits of the product. `done_o` is high n+1 cycles after the start cycle, where n is the bit length of `op_b_i`, with a minimum of 1.
- R5: MULH, MULHSU and MULHU return the upper 32 bits of the 64-bit product. Operand a is signed for MULH and MULHSU. Operand b is signed only for MULH. `done_o` is high 36 cycles after the start cycle, after 32 iteration steps.
- R6: DIV and DIVU return the quotient truncated toward zero. REM and REMU return the remainder, which takes the sign of the dividend. With a nonzero divisor, `done_o` is high 36 cycles after the start cycle, so the operation spans 37 cycles.
- R7: With a zero divisor, `done_o` is high 2 cycles after the start cycle. DIV and DIVU return all ones. REM and REMU return the dividend unchanged.
- R8: For a signed division of 0x80000000 by 0xFFFFFFFF, DIV returns 0x80000000 and REM returns 0.
- R9: While `rst_ni` is low, `busy_o`, `done_o` and `result_o` are 0.
- R10: A start in the cycle where `done_o` is high is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request pulse |
| op_i | input | 3 | Operation code (R1) |
| op_a_i | input | 32 | First operand, multiplicand or dividend |
| op_b_i | input | 32 | Second operand, multiplier or divisor |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion strobe |
| result_o | output | 32 | Result, valid while done_o is high |

## Verification
Two functions can fall in the same cycle: completion of one operation and acceptance of the next. A start can also arrive during the busy window of an operation in flight. The bench issues a new request exactly in the cycle its model predicts for `done_o`. It also issues requests two cycles after an accepted one, while the unit is busy. A behavioural model built from integer arithmetic and a countdown judges every cycle. It checks that the first case starts a new operation with no idle cycle, and that the second case leaves the running operation's latency and result unchanged.

// File: rtl/seq_muldiv_pkg.sv
package seq_muldiv_pkg;

  typedef enum logic [2:0] {
    OP_MUL    = 3'd0,
    OP_MULH   = 3'd1,
    OP_MULHSU = 3'd2,
    OP_MULHU  = 3'd3,
    OP_DIV    = 3'd4,
    OP_DIVU   = 3'd5,
    OP_REM    = 3'd6,
    OP_REMU   = 3'd7
  } md_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ABS_A,
    ST_ABS_B,
    ST_ITER,
    ST_FIX
  } md_state_e;

  function automatic logic op_a_signed(md_op_e op);
    return op inside {OP_MULH, OP_MULHSU, OP_DIV, OP_REM};
  endfunction

  function automatic logic op_b_signed(md_op_e op);
    return op inside {OP_MULH, OP_DIV, OP_REM};
  endfunction

  function automatic logic op_is_div(md_op_e op);
    return op[2];
  endfunction

  function automatic logic op_is_rem(md_op_e op);
    return op[2] & op[1];
  endfunction

endpackage

// File: rtl/seq_muldiv_negate.sv
// out = ~x + cin : full two's complement negate with cin=1,
// upper-half negate of a wide value with cin = (lower half == 0)
module seq_muldiv_negate #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] x_i,
  input  logic         cin_i,
  output logic [W-1:0] y_o
);
  assign y_o = ~x_i + {{(W-1){1'b0}}, cin_i};
endmodule

// File: rtl/seq_muldiv_ctrl.sv
module seq_muldiv_ctrl
  import seq_muldiv_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      start_i,
  input  md_op_e    op_i,
  input  logic      div_zero_i,
  input  logic      mul_last_i,
  output md_state_e state_o,
  output md_op_e    op_q_o,
  output logic      accept_o,
  output logic      fin_o,
  output logic      done_o
);
  localparam int unsigned CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(W - 1);

  md_state_e     state_q, state_d;
  md_op_e        op_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_q;

  assign accept_o = start_i && (state_q == ST_IDLE);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    fin_o   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = (op_i == OP_MUL) ? ST_ITER : ST_ABS_A;
          cnt_d   = '0;
        end
      end
      ST_ABS_A: begin
        if (op_is_div(op_q) && div_zero_i) begin
          state_d = ST_IDLE;
          fin_o   = 1'b1;
        end else begin
          state_d = ST_ABS_B;
        end
      end
      ST_ABS_B: begin
        state_d = ST_ITER;
        cnt_d   = '0;
      end
      ST_ITER: begin
        if (op_q == OP_MUL) begin
          // low half: stop once no multiplier bits remain
          if (mul_last_i) begin
            state_d = ST_IDLE;
            fin_o   = 1'b1;
          end
        end else if (cnt_q == CNT_LAST) begin
          state_d = ST_FIX;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_FIX: begin
        state_d = ST_IDLE;
        fin_o   = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      op_q    <= OP_MUL;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= fin_o;
      if (accept_o) op_q <= op_i;
    end
  end

  assign state_o = state_q;
  assign op_q_o  = op_q;
  assign done_o  = done_q;
endmodule

// File: rtl/seq_muldiv_dp.sv
module seq_muldiv_dp
  import seq_muldiv_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         accept_i,
  input  md_op_e       op_i,
  input  logic [W-1:0] op_a_i,
  input  logic [W-1:0] op_b_i,
  input  md_state_e    state_i,
  input  md_op_e       op_q_i,
  input  logic         fin_i,
  output logic         div_zero_o,
  output logic         mul_last_o,
  output logic [W-1:0] result_o
);
  localparam int unsigned DW = 2 * W;

  // mcand_q: multiplicand (shifts left) / dividend->quotient in low W bits
  // mplr_q : multiplier (shifts right) / divisor
  // acc_q  : product / partial remainder in low W bits
  logic [DW-1:0] mcand_q, acc_q;
  logic [W-1:0]  mplr_q, res_q;
  logic          sa_q, sb_q;

  logic          is_div, is_rem, res_neg;
  logic [W-1:0]  neg_in, neg_out, fix_val;
  logic          neg_cin;
  logic [DW-1:0] addend, prod_nx;
  logic [W:0]    rem_sh, rem_dif;
  logic          rem_ge;

  assign is_div  = op_is_div(op_q_i);
  assign is_rem  = op_is_rem(op_q_i);
  assign res_neg = is_rem ? sa_q : (sa_q ^ sb_q);

  assign div_zero_o = (mplr_q == '0);
  assign mul_last_o = (mplr_q[W-1:1] == '0);

  // single negator shared by both operand preps and the final sign fix
  always_comb begin
    neg_in  = '0;
    neg_cin = 1'b1;
    unique case (state_i)
      ST_ABS_A: neg_in = mcand_q[W-1:0];
      ST_ABS_B: neg_in = mplr_q;
      default: begin
        if (!is_div) begin
          neg_in  = acc_q[DW-1:W];
          neg_cin = (acc_q[W-1:0] == '0);
        end else if (is_rem) begin
          neg_in = acc_q[W-1:0];
        end else begin
          neg_in = mcand_q[W-1:0];
        end
      end
    endcase
  end

  seq_muldiv_negate #(.W(W)) u_neg (
    .x_i  (neg_in),
    .cin_i(neg_cin),
    .y_o  (neg_out)
  );

  assign fix_val = res_neg ? neg_out : neg_in;

  assign addend  = mplr_q[0] ? mcand_q : '0;
  assign prod_nx = acc_q + addend;

  assign rem_sh  = {acc_q[W-1:0], mcand_q[W-1]};
  assign rem_ge  = (rem_sh >= {1'b0, mplr_q});
  assign rem_dif = rem_sh - {1'b0, mplr_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mcand_q <= '0;
      acc_q   <= '0;
      mplr_q  <= '0;
      sa_q    <= 1'b0;
      sb_q    <= 1'b0;
    end else if (accept_i) begin
      mcand_q <= {{W{1'b0}}, op_a_i};
      mplr_q  <= op_b_i;
      acc_q   <= '0;
      sa_q    <= op_a_signed(op_i) & op_a_i[W-1];
      sb_q    <= op_b_signed(op_i) & op_b_i[W-1];
    end else begin
      unique case (state_i)
        ST_ABS_A: if (sa_q) mcand_q[W-1:0] <= neg_out;
        ST_ABS_B: if (sb_q) mplr_q <= neg_out;
        ST_ITER: begin
          if (!is_div) begin
            acc_q   <= prod_nx;
            mcand_q <= mcand_q << 1;
            mplr_q  <= mplr_q >> 1;
          end else begin
            acc_q[W-1:0]   <= rem_ge ? rem_dif[W-1:0] : rem_sh[W-1:0];
            mcand_q[W-1:0] <= {mcand_q[W-2:0], rem_ge};
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q <= '0;
    end else if (fin_i) begin
      unique case (state_i)
        ST_ABS_A: res_q <= is_rem ? mcand_q[W-1:0] : '1;  // zero divisor
        ST_ITER:  res_q <= prod_nx[W-1:0];                // low-half product
        default:  res_q <= fix_val;
      endcase
    end
  end

  assign result_o = res_q;
endmodule

// File: rtl/seq_muldiv.sv
module seq_muldiv
  import seq_muldiv_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [2:0]   op_i,
  input  logic [W-1:0] op_a_i,
  input  logic [W-1:0] op_b_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] result_o
);
  md_op_e    op_in, op_q;
  md_state_e state;
  logic      accept, fin, div_zero, mul_last;

  assign op_in = md_op_e'(op_i);

  seq_muldiv_ctrl #(.W(W)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .op_i      (op_in),
    .div_zero_i(div_zero),
    .mul_last_i(mul_last),
    .state_o   (state),
    .op_q_o    (op_q),
    .accept_o  (accept),
    .fin_o     (fin),
    .done_o    (done_o)
  );

  seq_muldiv_dp #(.W(W)) u_dp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .accept_i  (accept),
    .op_i      (op_in),
    .op_a_i    (op_a_i),
    .op_b_i    (op_b_i),
    .state_i   (state),
    .op_q_i    (op_q),
    .fin_i     (fin),
    .div_zero_o(div_zero),
    .mul_last_o(mul_last),
    .result_o  (result_o)
  );

  assign busy_o = (state != ST_IDLE);
endmodule

// File: rtl/seq_muldiv_chk.sv
module seq_muldiv_chk #(
  parameter int unsigned W = 32
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         start_i,
  input logic [2:0]   op_i,
  input logic [W-1:0] op_b_i,
  input logic         busy_o,
  input logic         done_o,
  input logic [W-1:0] result_o
);
  localparam int unsigned LW = $clog2(W + 8) + 1;

  logic [LW-1:0] lat_q;
  logic          trk_mul_q, trk_zero_q, trk_long_q, trk_rem_q;
  logic          acc;

  assign acc = start_i && !busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q      <= '0;
      trk_mul_q  <= 1'b0;
      trk_zero_q <= 1'b0;
      trk_long_q <= 1'b0;
      trk_rem_q  <= 1'b0;
    end else if (acc) begin
      lat_q      <= LW'(1);
      trk_mul_q  <= (op_i == 3'd0);
      trk_zero_q <= op_i[2] && (op_b_i == '0);
      trk_long_q <= (op_i != 3'd0) && !(op_i[2] && (op_b_i == '0));
      trk_rem_q  <= op_i[2] & op_i[1];
    end else if (lat_q != '0 && lat_q != '1) begin
      lat_q <= lat_q + 1'b1;
    end
  end

  assert_done_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_not_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  assert_busy_held_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> (busy_o || done_o));

  assert_mul_latency_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && trk_mul_q) |-> (lat_q >= LW'(2) && lat_q <= LW'(W + 1)));

  // covers R5 and R6
  assert_full_latency_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && trk_long_q) |-> (lat_q == LW'(W + 4)));

  assert_zero_div_fast_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && op_i[2] && op_b_i == '0) |=> busy_o ##1 done_o);

  assert_zero_div_ones_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && trk_zero_q && !trk_rem_q) |-> (result_o == '1));

  assert_reset_idle_R9: assert property (@(posedge clk_i)
    !rst_ni |-> (!busy_o && !done_o && result_o == '0));

  assert_accept_on_done_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && start_i) |=> busy_o);
endmodule

bind seq_muldiv seq_muldiv_chk #(.W(W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .op_i    (op_i),
  .op_b_i  (op_b_i),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .result_o(result_o)
);

// File: tb/seq_muldiv_test.sv
module seq_muldiv_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic [2:0]   op_i = '0;
  logic [W-1:0] op_a_i = '0, op_b_i = '0;
  logic         busy_o, done_o;
  logic [W-1:0] result_o;

  int    n_cmp = 0, n_bad = 0;
  bit    m_pend = 0;
  int    m_cnt = 0;
  logic [W-1:0] m_res = '0;
  string m_tag = "R1";

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  seq_muldiv #(.W(W)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .op_i(op_i),
    .op_a_i(op_a_i), .op_b_i(op_b_i), .busy_o(busy_o), .done_o(done_o),
    .result_o(result_o)
  );

  task automatic cmp(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] ref_res(logic [2:0] op, logic [W-1:0] a, logic [W-1:0] b);
    longint sa = longint'($signed(a));
    longint sb = longint'($signed(b));
    longint unsigned ua = {32'b0, a};
    longint unsigned ub = {32'b0, b};
    longint unsigned pu;
    longint ps;
    bit ovf = (a == 32'h8000_0000) && (b == 32'hFFFF_FFFF);
    case (op)
      3'd0: begin pu = ua * ub; return pu[31:0]; end
      3'd1: begin ps = sa * sb; return ps[63:32]; end
      3'd2: begin ps = sa * longint'(ub); return ps[63:32]; end
      3'd3: begin pu = ua * ub; return pu[63:32]; end
      3'd4: begin
        if (b == 0) return '1;
        if (ovf) return a;
        ps = sa / sb; return ps[31:0];
      end
      3'd5: return (b == 0) ? '1 : a / b;
      3'd6: begin
        if (b == 0) return a;
        if (ovf) return '0;
        ps = sa % sb; return ps[31:0];
      end
      default: return (b == 0) ? a : a % b;
    endcase
  endfunction

  function automatic int lat_of(logic [2:0] op, logic [W-1:0] b);
    int n = 0;
    if (op == 3'd0) begin
      for (int i = 0; i < W; i++) if (b[i]) n = i + 1;
      if (n == 0) n = 1;
      return n + 1;
    end
    if (op[2] && b == 0) return 2;
    return W + 4;
  endfunction

  function automatic string tag_of(logic [2:0] op, logic [W-1:0] a, logic [W-1:0] b);
    if (op == 3'd0) return "R4";
    if (!op[2]) return "R5";
    if (b == 0) return "R7";
    if ((op == 3'd4 || op == 3'd6) && a == 32'h8000_0000 && b == 32'hFFFF_FFFF) return "R8";
    return "R6";
  endfunction

  // one cycle: judge outputs against the model, then drive this cycle's inputs
  task automatic step(logic s, logic [2:0] op, logic [W-1:0] a, logic [W-1:0] b);
    bit exp_done, exp_busy;
    @(negedge clk_i);
    if (m_pend) m_cnt--;
    exp_done = m_pend && (m_cnt == 0);
    exp_busy = m_pend && (m_cnt > 0);
    cmp("R2", "busy", {31'b0, busy_o}, {31'b0, exp_busy});
    cmp(m_tag, "done", {31'b0, done_o}, {31'b0, exp_done});
    if (exp_done) begin
      cmp(m_tag, "result", result_o, m_res);
      m_pend = 0;
    end
    start_i = s;
    op_i    = op;
    op_a_i  = a;
    op_b_i  = b;
    if (s) begin
      if (exp_busy) m_tag = "R3";
      else begin
        m_pend = 1;
        m_cnt  = lat_of(op, b);
        m_res  = ref_res(op, a, b);
        m_tag  = exp_done ? "R10" : tag_of(op, a, b);
      end
    end
  endtask

  task automatic issue(logic [2:0] op, logic [W-1:0] a, logic [W-1:0] b);
    step(1'b1, op, a, b);
    while (m_pend && m_cnt > 1) step(1'b0, 3'd0, '0, '0);
  endtask

  task automatic drain();
    while (m_pend) step(1'b0, 3'd0, '0, '0);
    step(1'b0, 3'd0, '0, '0);
  endtask

  task automatic run(logic [2:0] op, logic [W-1:0] a, logic [W-1:0] b);
    issue(op, a, b);
    drain();
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    // R9: idle outputs under reset
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i);
      cmp("R9", "busy", {31'b0, busy_o}, '0);
      cmp("R9", "done", {31'b0, done_o}, '0);
      cmp("R9", "result", result_o, '0);
    end
    rst_ni = 1'b1;

    // R4: low-half product, data-dependent latency
    run(3'd0, 32'd7, 32'd0);
    run(3'd0, 32'd123, 32'd1);
    run(3'd0, 32'd99, 32'd5);
    run(3'd0, 32'h1234_5678, 32'hFFFF_FFFF);
    run(3'd0, 32'hFFFF_FFFD, 32'd5);
    // R5: high halves, R1 opcodes
    run(3'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    run(3'd1, 32'h8000_0000, 32'h8000_0000);
    run(3'd1, 32'h7FFF_FFFF, 32'h8000_0000);
    run(3'd2, 32'hFFFF_FFFE, 32'hFFFF_FFFF);
    run(3'd2, 32'h8000_0000, 32'h0000_0003);
    run(3'd3, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    // R6: signed and unsigned division
    run(3'd4, 32'hFFFF_FFF9, 32'd2);
    run(3'd4, 32'd7, 32'hFFFF_FFFE);
    run(3'd6, 32'hFFFF_FFF9, 32'd2);
    run(3'd6, 32'd7, 32'hFFFF_FFFE);
    run(3'd5, 32'hFFFF_FFFF, 32'd3);
    run(3'd7, 32'hFFFF_FFFF, 32'd3);
    run(3'd5, 32'h8000_0000, 32'hFFFF_FFFF);
    run(3'd7, 32'd5, 32'hFFFF_FFFF);
    // R7: zero divisor
    run(3'd4, 32'hFFFF_FFFB, 32'd0);
    run(3'd5, 32'hFFFF_FFFB, 32'd0);
    run(3'd6, 32'hFFFF_FFFB, 32'd0);
    run(3'd7, 32'hFFFF_FFFB, 32'd0);
    // R8: signed overflow
    run(3'd4, 32'h8000_0000, 32'hFFFF_FFFF);
    run(3'd6, 32'h8000_0000, 32'hFFFF_FFFF);

    // R3: starts during busy are dropped
    step(1'b1, 3'd4, 32'd100, 32'd7);
    step(1'b0, 3'd0, '0, '0);
    step(1'b1, 3'd3, 32'hFFFF_FFFF, 32'd9);
    step(1'b1, 3'd0, 32'd3, 32'd0);
    drain();
    step(1'b1, 3'd0, 32'd11, 32'd13);
    step(1'b1, 3'd4, 32'd1, 32'd0);
    drain();

    // R10: next request in the done cycle
    issue(3'd1, 32'h1234_5678, 32'h8765_4321);
    issue(3'd6, 32'd42, 32'd0);
    issue(3'd0, 32'd6, 32'd6);
    issue(3'd5, 32'd1000, 32'd7);
    drain();

    for (int k = 0; k < 300; k++) begin
      logic [2:0]   rop = 3'($urandom % 8);
      logic [W-1:0] ra  = $urandom;
      logic [W-1:0] rb;
      case ($urandom % 4)
        0: rb = '0;
        1: rb = $urandom % 16;
        2: rb = -($urandom % 4);
        default: rb = $urandom;
      endcase
      if ($urandom % 8 == 0) ra = 32'h8000_0000;
      if ($urandom % 3 == 0) issue(rop, ra, rb);
      else run(rop, ra, rb);
    end
    drain();

    summary();
    $finish;
  end
endmodule